// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers two active-low PCI interrupt request lines onto the sixteen request inputs of a legacy programmable interrupt controller. Each PCI line owns one byte-wide route register on a simple register bus. The register holds an enable bit, which is active low, and a 4-bit target code. The code space is sparse: five of the sixteen codes are reserved, and a line set to one of them routes nowhere.

Any IRQ that at least one enabled line targets is "claimed". On a claimed IRQ the legacy ISA request is blocked, and the controller input follows the PCI request, converted to active high. When both lines target the same IRQ, their requests are wired-OR. Every IRQ that is not claimed passes its ISA request through unchanged. A per-IRQ flag marks each claimed input so that the edge/level logic can switch that input to level-sensitive triggering.

A register write is captured on the next clock edge. Read data, the controller inputs and the level flags are combinational from the register contents and the input lines.

Top module: `intr_line_router`

## Requirements
- R1: Line 0's register is at byte address 60h and line 1's is at 61h. A write with `reg_wr` high updates the addressed register at the next rising clock edge. A read of any other address returns 00h, and a write to any other address changes no register.
- R2: After reset both registers read 80h, so no line is routed.
- R3: Bit 7 of a register is the routing enable and is active low. While bit 7 is 1, the line claims no IRQ.
- R4: Bits 6:4 always read as zero, whatever was written to them. Bits 7 and 3:0 read back exactly as written.
- R5: With routing enabled, code values 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 in bits 3:0 target the IRQ with the same number.
- R6: Code values 0, 1, 2, 8 and 13 are reserved. A line holding one of them claims no IRQ, even with routing enabled.
- R7: `pci_req_n[n]` is active low. A claimed IRQ's `pic_irq` bit is 1 exactly when at least one line targeting it has its request at 0.
- R8: When both lines target the same IRQ, that `pic_irq` bit is the OR of both active-high requests.
- R9: On a claimed IRQ, `isa_irq` has no effect on `pic_irq`.
- R10: On an IRQ that is not claimed, `pic_irq` equals `isa_irq`.
- R11: `level_req[i]` is 1 exactly when IRQ i is claimed.
- R12: `pic_irq`, `level_req` and `reg_rdata` respond within the same cycle to changes on `pci_req_n`, `isa_irq` and `reg_addr`, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pci_req_n | input | 2 | Active-low PCI interrupt requests, bit 0 is line 0 |
| isa_irq | input | 16 | Legacy ISA requests, active high, one per IRQ |
| pic_irq | output | 16 | Requests to the interrupt controller, active high |
| level_req | output | 16 | Per-IRQ flag for level-sensitive mode |

## Verification
The bench sweeps every code on both lines with each enable combination. This exposes a decoder that passes a reserved code through: such a design would raise a controller input and its level flag where both should stay clear. It also catches a decoder that shifts the code-to-IRQ map by one. Shared targets are driven with each pair of request levels, so an AND or a last-writer-wins merge shows up as a missing request. Random ISA activity under claimed IRQs exposes a mask that is left open. Writes of 1s to the reserved bits and writes to a neighbouring address test the readback and the address decode.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;

  localparam int unsigned IRQ_COUNT = 16;
  localparam int unsigned CODE_W    = 4;

  // set bit = code value that names a real controller input
  localparam logic [IRQ_COUNT-1:0] CODE_LEGAL = 16'hDEF8;

  typedef struct packed {
    logic              off;   // active-high "routing off" (register bit 7)
    logic [CODE_W-1:0] code;  // target selector (register bits 3:0)
  } route_cfg_t;

  localparam route_cfg_t CFG_RESET = '{off: 1'b1, code: '0};

endpackage

// File: rtl/intr_route_reg.sv
module intr_route_reg
  import intr_route_pkg::*;
#(
  parameter int unsigned            ADDR_W  = 8,
  parameter int unsigned            DATA_W  = 8,
  parameter logic [ADDR_W-1:0]      MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output route_cfg_t        cfg,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned PAD_W = DATA_W - 1 - CODE_W;

  logic       sel;
  logic       cfg_we;
  route_cfg_t cfg_d;
  route_cfg_t cfg_q;

  always_comb begin
    sel    = (bus_addr == MY_ADDR);
    cfg_we = sel && bus_wr;
    cfg_d  = cfg_q;
    if (cfg_we) begin
      cfg_d.off  = bus_wdata[DATA_W-1];
      cfg_d.code = bus_wdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = sel ? {cfg_q.off, {PAD_W{1'b0}}, cfg_q.code} : '0;

  // R1
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel) |=> (cfg_q.off == $past(bus_wdata[DATA_W-1]) &&
                         cfg_q.code == $past(bus_wdata[CODE_W-1:0])));

  // R1
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel) |=> $stable(cfg_q));

endmodule

// File: rtl/intr_route_decode.sv
module intr_route_decode
  import intr_route_pkg::*;
#(
  parameter int unsigned N_IRQ = IRQ_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  route_cfg_t       cfg,
  input  logic             req_n,
  output logic [N_IRQ-1:0] target,
  output logic [N_IRQ-1:0] active
);

  logic req;
  assign req = ~req_n;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    always_comb begin
      target[g] = !cfg.off && (cfg.code == CODE_W'(g)) && CODE_LEGAL[g];
      active[g] = target[g] && req;
    end
  end

  // R5
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(target));

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.off |-> (target == '0));

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.code == 4'd0 || cfg.code == 4'd1 || cfg.code == 4'd2 ||
     cfg.code == 4'd8 || cfg.code == 4'd13) |-> (target == '0));

endmodule

// File: rtl/intr_route_merge.sv
module intr_route_merge #(
  parameter int unsigned N_LINES = 2,
  parameter int unsigned N_IRQ   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_LINES-1:0][N_IRQ-1:0]  target,
  input  logic [N_LINES-1:0][N_IRQ-1:0]  active,
  input  logic [N_IRQ-1:0]               legacy,
  output logic [N_IRQ-1:0]               to_pic,
  output logic [N_IRQ-1:0]               level
);

  logic [N_IRQ-1:0] claimed;
  logic [N_IRQ-1:0] pci_any;

  always_comb begin
    claimed = '0;
    pci_any = '0;
    for (int l = 0; l < N_LINES; l++) begin
      claimed = claimed | target[l];
      pci_any = pci_any | active[l];
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_out
    assign to_pic[g] = claimed[g] ? pci_any[g] : legacy[g];
    assign level[g]  = claimed[g];

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !level[g] |-> (to_pic[g] == legacy[g]));

    // R9
    legacy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level[g] && !pci_any[g]) |-> !to_pic[g]);
  end

endmodule

// File: rtl/intr_line_router.sv
module intr_line_router
  import intr_route_pkg::*;
#(
  parameter int unsigned          N_LINES   = 2,
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          DATA_W    = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 8'h60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [N_LINES-1:0]   pci_req_n,
  input  logic [IRQ_COUNT-1:0] isa_irq,
  output logic [IRQ_COUNT-1:0] pic_irq,
  output logic [IRQ_COUNT-1:0] level_req
);

  localparam int unsigned N_IRQ = IRQ_COUNT;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  route_cfg_t [N_LINES-1:0]             cfg;
  logic       [N_LINES-1:0][DATA_W-1:0] line_rd;
  logic       [N_LINES-1:0][N_IRQ-1:0]  target;
  logic       [N_LINES-1:0][N_IRQ-1:0]  active;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    intr_route_reg #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .MY_ADDR (ADDR_W'(BASE_ADDR + l))
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .bus_addr  (reg_addr),
      .bus_wr    (reg_wr),
      .bus_wdata (reg_wdata),
      .cfg       (cfg[l]),
      .rd_data   (line_rd[l])
    );

    intr_route_decode #(
      .N_IRQ (N_IRQ)
    ) u_dec (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cfg    (cfg[l]),
      .req_n  (pci_req_n[l]),
      .target (target[l]),
      .active (active[l])
    );

    // R7
    routed_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!cfg[l].off && CODE_LEGAL[cfg[l].code] && !pci_req_n[l])
        |-> pic_irq[cfg[l].code]);

    // R11
    level_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!cfg[l].off && CODE_LEGAL[cfg[l].code]) |-> level_req[cfg[l].code]);
  end

  always_comb begin
    reg_rdata = '0;
    for (int l = 0; l < N_LINES; l++) begin
      reg_rdata = reg_rdata | line_rd[l];
    end
  end

  intr_route_merge #(
    .N_LINES (N_LINES),
    .N_IRQ   (N_IRQ)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .target (target),
    .active (active),
    .legacy (isa_irq),
    .to_pic (pic_irq),
    .level  (level_req)
  );

  // R4
  pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rdata[DATA_W-2:CODE_W] == '0);

endmodule

// File: tb/intr_line_router_bench.sv
module intr_line_router_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [1:0]  pci_req_n;
  logic [15:0] isa_irq;
  logic [15:0] pic_irq;
  logic [15:0] level_req;

  int tests = 0;
  int fails = 0;

  // what each register should hold (readback form)
  logic [7:0] shadow [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_line_router u_intr_line_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pci_req_n (pci_req_n),
    .isa_irq   (isa_irq),
    .pic_irq   (pic_irq),
    .level_req (level_req)
  );

  function automatic bit code_ok(input logic [3:0] c);
    return c inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11,
                     4'd12, 4'd14, 4'd15};
  endfunction

  function automatic logic [15:0] claim_of(input logic [7:0] r);
    logic [15:0] m = '0;
    if (!r[7] && code_ok(r[3:0])) m[r[3:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] exp_level(input logic [7:0] a, input logic [7:0] b);
    return claim_of(a) | claim_of(b);
  endfunction

  function automatic logic [15:0] exp_pic(input logic [7:0] a, input logic [7:0] b,
                                          input logic [1:0] pn, input logic [15:0] isa);
    logic [15:0] ca = claim_of(a);
    logic [15:0] cb = claim_of(b);
    logic [15:0] req = (pn[0] ? 16'h0 : ca) | (pn[1] ? 16'h0 : cb);
    return (isa & ~(ca | cb)) | req;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
    if (a == 8'h60) shadow[0] = {d[7], 3'b000, d[3:0]};
    if (a == 8'h61) shadow[1] = {d[7], 3'b000, d[3:0]};
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic out_chk(input string tag, input logic [1:0] pn, input logic [15:0] isa);
    pci_req_n = pn;
    isa_irq   = isa;
    #1;
    check({tag, " pic"}, pic_irq, exp_pic(shadow[0], shadow[1], pn, isa));
    check("R11 level", level_req, exp_level(shadow[0], shadow[1]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_addr = 8'h00; reg_wr = 1'b0; reg_wdata = 8'h00;
    pci_req_n = 2'b11; isa_irq = 16'h0000;
    shadow[0] = 8'h80; shadow[1] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    read_chk("R2 reset line0", 8'h60, 8'h80);
    read_chk("R2 reset line1", 8'h61, 8'h80);
    out_chk("R2/R10 reset", 2'b00, 16'hA5C3);

    // R4 pad bits read zero
    write_reg(8'h60, 8'hFF);
    read_chk("R4 pad line0", 8'h60, 8'h8F);
    write_reg(8'h61, 8'h75);
    read_chk("R4 pad line1", 8'h61, 8'h05);

    // R1 neighbour address: reads zero, writes ignored
    write_reg(8'h62, 8'h03);
    read_chk("R1 unmapped read", 8'h62, 8'h00);
    read_chk("R1 line0 untouched", 8'h60, 8'h8F);
    read_chk("R1 line1 untouched", 8'h61, 8'h05);
    out_chk("R1 no stray route", 2'b00, 16'h0000);

    // R12 combinational response without a clock edge
    write_reg(8'h60, 8'h0E);
    write_reg(8'h61, 8'h80);
    out_chk("R12 req high", 2'b11, 16'h4000);
    out_chk("R12 req low", 2'b10, 16'h0000);

    // R8 shared target, all request pairs
    write_reg(8'h60, 8'h0B);
    write_reg(8'h61, 8'h0B);
    for (int p = 0; p < 4; p++) out_chk("R8 shared", 2'(p), 16'hFFFF);

    // R3/R5/R6/R7/R9 sweep of every code and enable combination
    for (int e = 0; e < 4; e++) begin
      for (int ca = 0; ca < 16; ca++) begin
        for (int cb = 0; cb < 16; cb++) begin
          write_reg(8'h60, {e[0], 3'($urandom), 4'(ca)});
          write_reg(8'h61, {e[1], 3'($urandom), 4'(cb)});
          for (int p = 0; p < 4; p++)
            out_chk("R3/R5/R6/R7/R9 sweep", 2'(p), 16'($urandom));
        end
      end
    end
    read_chk("R4 after sweep", 8'h61, shadow[1]);

    // random mix of writes, reads and input patterns
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a = 8'h5F + 8'($urandom_range(0, 3));
      write_reg(a, 8'($urandom));
      read_chk("R1/R4 random read", 8'h60, shadow[0]);
      read_chk("R1/R4 random read", 8'h61, shadow[1]);
      out_chk("R7/R8/R9/R10 random", 2'($urandom), 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule